// File: doc/BRIEF.md
# Paged Memory Bank Mapper

This block sits between a CPU's 16-bit address bus and a set of backing memories. It splits the space into 256 pages of 256 bytes each. For each page it holds one bank code for reads and one for writes. Eleven mode flags decide the codes. They cover the zero-page/stack swap, display page selection, the 80-column store window, hi-res, auxiliary read and write, the slot ROM choices and the upper RAM controls.

The table is rebuilt from a fixed, layered set of rules, applied in order so that later rules override earlier ones:

1. The base map.
2. The zero-page swap.
3. The auxiliary read and write split.
4. The display windows.
5. The slot ROM rules.
6. The upper 12 KB.
7. The 4 KB bank-2 window.

Any change on the flags marks the table stale. The table is rebuilt on the next clock edge, so for the two edges after a flag change, `map_stale` warns the requester not to issue an access. An access looks up its page combinationally and returns a 3-bit bank code. A write that lands on a read-only bank is flagged for discarding.

Top module: `page_bank_mapper`

## Requirements
- R1: Bank codes are 0 main, 1 upper, 2 upper bank-2, 3 aux, 4 aux upper, 5 aux upper bank-2, 6 system ROM, 7 card ROM. With no other rule applying, pages 0x00–0xC0 map to main and pages 0xC1–0xFF map to system ROM, for both read and write.
- R2: With the zero-page swap flag set, pages 0x00–0x01 map to aux for read and write.
- R3: For pages 0x02–0xBF, the aux-read flag picks aux or main for reads, and the aux-write flag does the same for writes, each on its own.
- R4: With 80-column store set, pages 0x04–0x07 map to aux when the display page-2 flag is set, and to main otherwise, for read and write, overriding R3. With hi-res also set, pages 0x20–0x3F follow the same rule.
- R5: With the internal slot ROM flag clear, reads of pages 0xC1–0xC7 map to card ROM, while writes keep system ROM.
- R6: Reads of page 0xC3 map to card ROM when the slot-3 flag is set, and to system ROM otherwise, regardless of R5.
- R7: For pages 0xD0–0xFF, reads map to upper RAM when the upper-read flag is set and to system ROM otherwise. Writes do the same under the upper-write flag. The upper RAM is the aux copy (code 4) when the zero-page swap flag is set.
- R8: With the bank-2 flag set, pages 0xD0–0xDF that selected upper RAM use the bank-2 variant instead (code 2, or code 5 for the aux copy).
- R9: `acc_drop` is high exactly when `acc_we` is high and the selected bank is system ROM or card ROM.
- R10: A flag change raises `map_stale` combinationally in the same cycle. It stays high after the next edge, and the new map is in effect and `map_stale` low after the second edge. After reset the map equals the all-flags-clear map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_zp | input | 1 | Zero page and stack from aux |
| disp_page2 | input | 1 | Display page 2 select |
| store80 | input | 1 | 80-column store window enable |
| hires | input | 1 | Hi-res window extension |
| aux_rd | input | 1 | Main-area reads from aux |
| aux_wr | input | 1 | Main-area writes to aux |
| int_slot_rom | input | 1 | Internal ROM over slot pages |
| slot3_rom | input | 1 | Slot-3 page from card ROM |
| up_rd | input | 1 | Upper area reads from RAM |
| up_wr | input | 1 | Upper area writes to RAM |
| up_bank2 | input | 1 | Lower 4 KB of upper area uses bank 2 |
| acc_addr | input | 16 | Access address |
| acc_we | input | 1 | Access is a write |
| acc_bank | output | 3 | Selected bank code |
| acc_drop | output | 1 | Write targets a read-only bank |
| map_stale | output | 1 | Flag change not yet applied to the table |

## Verification
The hardest situation to reach is a page where several layers disagree. Examples are an 80-column window page under aux-read, page 0xC3 with the slot ROM flags in opposite states, and a bank-2 page under the zero-page swap. In each case only the correct override order gives the right code. The directed tasks stack the flags on purpose to reach these pages. They probe both the read and the write code of the same page, so a wrongly ordered layer shows up on one side or the other. The rebuild timing is checked by probing `map_stale` in the cycle of the change and after each of the next two edges.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

    localparam int PAGE_W = 8;

    typedef enum logic [2:0] {
        BK_MAIN         = 3'd0,
        BK_UPPER        = 3'd1,
        BK_UPPER_B2     = 3'd2,
        BK_AUX          = 3'd3,
        BK_AUX_UPPER    = 3'd4,
        BK_AUX_UPPER_B2 = 3'd5,
        BK_ROM          = 3'd6,
        BK_CARD         = 3'd7
    } bank_e;

    typedef struct packed {
        logic alt_zp;
        logic disp_page2;
        logic store80;
        logic hires;
        logic aux_rd;
        logic aux_wr;
        logic int_slot_rom;
        logic slot3_rom;
        logic up_rd;
        logic up_wr;
        logic up_bank2;
    } mode_t;

    typedef struct packed {
        bank_e rd;
        bank_e wr;
    } page_map_t;

    // page window limits (behavioural boundaries)
    localparam logic [7:0] PG_RAM_TOP   = 8'hC0;
    localparam logic [7:0] PG_ZP_TOP    = 8'h01;
    localparam logic [7:0] PG_MAIN_LO   = 8'h02;
    localparam logic [7:0] PG_MAIN_HI   = 8'hBF;
    localparam logic [7:0] PG_TXT_LO    = 8'h04;
    localparam logic [7:0] PG_TXT_HI    = 8'h07;
    localparam logic [7:0] PG_HGR_LO    = 8'h20;
    localparam logic [7:0] PG_HGR_HI    = 8'h3F;
    localparam logic [7:0] PG_SLOT_LO   = 8'hC1;
    localparam logic [7:0] PG_SLOT_HI   = 8'hC7;
    localparam logic [7:0] PG_SLOT3     = 8'hC3;
    localparam logic [7:0] PG_UP_LO     = 8'hD0;
    localparam logic [7:0] PG_B2_HI     = 8'hDF;

endpackage

// File: rtl/pgmap_rule.sv
module pgmap_rule
    import pgmap_pkg::*;
#(
    parameter logic [7:0] PAGE = 8'h00
) (
    input  mode_t     mode,
    output page_map_t map
);

    localparam bit IN_RAM  = (PAGE <= PG_RAM_TOP);
    localparam bit IN_ZP   = (PAGE <= PG_ZP_TOP);
    localparam bit IN_MAIN = (PAGE >= PG_MAIN_LO) && (PAGE <= PG_MAIN_HI);
    localparam bit IN_TXT  = (PAGE >= PG_TXT_LO) && (PAGE <= PG_TXT_HI);
    localparam bit IN_HGR  = (PAGE >= PG_HGR_LO) && (PAGE <= PG_HGR_HI);
    localparam bit IN_SLOT = (PAGE >= PG_SLOT_LO) && (PAGE <= PG_SLOT_HI);
    localparam bit IS_S3   = (PAGE == PG_SLOT3);
    localparam bit IN_UP   = (PAGE >= PG_UP_LO);
    localparam bit IN_B2   = (PAGE >= PG_UP_LO) && (PAGE <= PG_B2_HI);

    bank_e up_bank, disp_bank;

    always_comb begin
        if (IN_B2 && mode.up_bank2)
            up_bank = mode.alt_zp ? BK_AUX_UPPER_B2 : BK_UPPER_B2;
        else
            up_bank = mode.alt_zp ? BK_AUX_UPPER : BK_UPPER;
        disp_bank = mode.disp_page2 ? BK_AUX : BK_MAIN;

        // layer 1: base map
        map.rd = IN_RAM ? BK_MAIN : BK_ROM;
        map.wr = map.rd;
        // layer 2: zero page swap
        if (IN_ZP && mode.alt_zp) begin
            map.rd = BK_AUX;
            map.wr = BK_AUX;
        end
        // layer 3: main area split
        if (IN_MAIN) begin
            map.rd = mode.aux_rd ? BK_AUX : BK_MAIN;
            map.wr = mode.aux_wr ? BK_AUX : BK_MAIN;
        end
        // layer 4: display windows
        if (mode.store80 && (IN_TXT || (IN_HGR && mode.hires))) begin
            map.rd = disp_bank;
            map.wr = disp_bank;
        end
        // layer 5: slot ROM (reads only)
        if (IN_SLOT && !mode.int_slot_rom)
            map.rd = BK_CARD;
        if (IS_S3)
            map.rd = mode.slot3_rom ? BK_CARD : BK_ROM;
        // layers 6 and 7: upper area with bank-2 window
        if (IN_UP) begin
            map.rd = mode.up_rd ? up_bank : BK_ROM;
            map.wr = mode.up_wr ? up_bank : BK_ROM;
        end
    end

endmodule

// File: rtl/pgmap_table.sv
module pgmap_table
    import pgmap_pkg::*;
#(
    parameter int PAGES = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rebuild,
    input  mode_t                       mode,
    output page_map_t [PAGES-1:0]       map_q
);

    page_map_t [PAGES-1:0] map_d;
    page_map_t [PAGES-1:0] fresh;
    page_map_t [PAGES-1:0] boot;
    mode_t                 clear_mode;

    assign clear_mode = '0;

    for (genvar p = 0; p < PAGES; p++) begin : g_page
        pgmap_rule #(.PAGE(8'(p))) u_live (.mode(mode),       .map(fresh[p]));
        pgmap_rule #(.PAGE(8'(p))) u_boot (.mode(clear_mode), .map(boot[p]));
    end

    always_comb begin
        map_d = rebuild ? fresh : map_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= boot;
        else        map_q <= map_d;
    end

    // R1: the last RAM page never leaves main
    a_r1_top_ram_page: assert property (@(posedge clk) disable iff (!rst_n)
        map_q[8'hC0].rd == BK_MAIN && map_q[8'hC0].wr == BK_MAIN);
    // R5: card ROM is never a write target
    a_r5_card_not_written: assert property (@(posedge clk) disable iff (!rst_n)
        map_q[8'hC1].wr == BK_ROM && map_q[8'hC7].wr == BK_ROM);
    // R8: bank-2 codes never appear above the 4 KB window
    a_r8_b2_window_only: assert property (@(posedge clk) disable iff (!rst_n)
        map_q[8'hE0].rd != BK_UPPER_B2 && map_q[8'hE0].rd != BK_AUX_UPPER_B2 &&
        map_q[8'hE0].wr != BK_UPPER_B2 && map_q[8'hE0].wr != BK_AUX_UPPER_B2);
    // R2: zero page is main or aux only
    a_r2_zero_page_ram: assert property (@(posedge clk) disable iff (!rst_n)
        map_q[0].rd == BK_MAIN || map_q[0].rd == BK_AUX);

endmodule

// File: rtl/pgmap_lookup.sv
module pgmap_lookup
    import pgmap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGES  = 256
) (
    input  page_map_t [PAGES-1:0] map,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  we,
    output logic [2:0]            bank,
    output logic                  drop
);

    logic [PAGE_W-1:0] page;
    bank_e             sel;

    always_comb begin
        page = addr[ADDR_W-1 -: PAGE_W];
        sel  = we ? map[page].wr : map[page].rd;
        bank = sel;
        drop = we && (sel == BK_ROM || sel == BK_CARD);
    end

endmodule

// File: rtl/page_bank_mapper.sv
module page_bank_mapper
    import pgmap_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_zp,
    input  logic              disp_page2,
    input  logic              store80,
    input  logic              hires,
    input  logic              aux_rd,
    input  logic              aux_wr,
    input  logic              int_slot_rom,
    input  logic              slot3_rom,
    input  logic              up_rd,
    input  logic              up_wr,
    input  logic              up_bank2,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_we,
    output logic [2:0]        acc_bank,
    output logic              acc_drop,
    output logic              map_stale
);

    localparam int PAGES = 1 << PAGE_W;

    typedef struct packed {
        mode_t mode;
        logic  dirty;
    } ctl_t;

    mode_t                 mode_in;
    ctl_t                  ctl_d, ctl_q;
    page_map_t [PAGES-1:0] map_q;

    assign mode_in = '{alt_zp, disp_page2, store80, hires, aux_rd, aux_wr,
                       int_slot_rom, slot3_rom, up_rd, up_wr, up_bank2};

    always_comb begin
        ctl_d.mode  = mode_in;
        ctl_d.dirty = (mode_in != ctl_q.mode);
        map_stale   = ctl_q.dirty || (mode_in != ctl_q.mode);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pgmap_table #(.PAGES(PAGES)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rebuild (ctl_q.dirty),
        .mode    (ctl_q.mode),
        .map_q   (map_q)
    );

    pgmap_lookup #(.ADDR_W(ADDR_W), .PAGES(PAGES)) u_lookup (
        .map  (map_q),
        .addr (acc_addr),
        .we   (acc_we),
        .bank (acc_bank),
        .drop (acc_drop)
    );

    // R10: a pending rebuild with steady flags clears after one edge
    a_r10_rebuild_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.dirty && mode_in == ctl_q.mode) |=> !map_stale);
    // R9: reads are never discarded
    a_r9_read_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_we |-> !acc_drop);

endmodule

// File: tb/page_bank_mapper_bench.sv
module page_bank_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [10:0] m;
    logic [15:0] acc_addr;
    logic        acc_we;
    logic [2:0]  acc_bank;
    logic        acc_drop;
    logic        map_stale;

    int checks = 0;
    int errors = 0;

    // flag bit positions in m
    localparam int F_ZP = 10, F_P2 = 9, F_S80 = 8, F_HR = 7, F_ARD = 6, F_AWR = 5,
                   F_ICX = 4, F_S3 = 3, F_URD = 2, F_UWR = 1, F_UB2 = 0;

    always #10 clk = ~clk;

    page_bank_mapper u_page_bank_mapper (
        .clk(clk), .rst_n(rst_n),
        .alt_zp(m[F_ZP]), .disp_page2(m[F_P2]), .store80(m[F_S80]), .hires(m[F_HR]),
        .aux_rd(m[F_ARD]), .aux_wr(m[F_AWR]), .int_slot_rom(m[F_ICX]),
        .slot3_rom(m[F_S3]), .up_rd(m[F_URD]), .up_wr(m[F_UWR]), .up_bank2(m[F_UB2]),
        .acc_addr(acc_addr), .acc_we(acc_we),
        .acc_bank(acc_bank), .acc_drop(acc_drop), .map_stale(map_stale)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic probe(input string req, input logic [15:0] a, input logic we,
                         input logic [2:0] exp_bank);
        acc_addr = a;
        acc_we   = we;
        #1;
        check(req, {1'b0, acc_bank}, {1'b0, exp_bank});
        check({req, " drop"}, {3'b0, acc_drop}, {3'b0, we && (exp_bank >= 3'd6)});
    endtask

    task automatic apply(input logic [10:0] v);
        @(negedge clk);
        m = v;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R10 reset stale", {3'b0, map_stale}, 4'd0);
        probe("R1 reset page 00", 16'h0012, 1'b0, 3'd0);
        probe("R1 reset page C0", 16'hC000, 1'b1, 3'd0);
        probe("R5 reset slot read", 16'hC500, 1'b0, 3'd7);
        probe("R5 reset slot write", 16'hC500, 1'b1, 3'd6);
        probe("R6 reset C3 read", 16'hC300, 1'b0, 3'd6);
        probe("R7 reset upper read", 16'hF000, 1'b0, 3'd6);
    endtask

    task automatic t_base;
        apply(11'b1 << F_ICX);
        probe("R1 slot read internal", 16'hC500, 1'b0, 3'd6);
        probe("R1 main write", 16'h8000, 1'b1, 3'd0);
        probe("R9 rom write dropped", 16'hFF00, 1'b1, 3'd6);
    endtask

    task automatic t_zero_page;
        apply((11'b1 << F_ZP) | (11'b1 << F_ICX));
        probe("R2 page 01 read", 16'h01FF, 1'b0, 3'd3);
        probe("R2 page 00 write", 16'h0000, 1'b1, 3'd3);
        probe("R2 page 02 stays", 16'h0200, 1'b0, 3'd0);
    endtask

    task automatic t_split;
        apply((11'b1 << F_ARD) | (11'b1 << F_ICX));
        probe("R3 read aux", 16'h1234, 1'b0, 3'd3);
        probe("R3 write main", 16'h1234, 1'b1, 3'd0);
        probe("R3 page BF read", 16'hBF00, 1'b0, 3'd3);
        probe("R3 page C0 untouched", 16'hC000, 1'b0, 3'd0);
        apply((11'b1 << F_AWR) | (11'b1 << F_ICX));
        probe("R3 write aux", 16'h0300, 1'b1, 3'd3);
        probe("R3 read main", 16'h0300, 1'b0, 3'd0);
    endtask

    task automatic t_display;
        apply((11'b1 << F_S80) | (11'b1 << F_ARD) | (11'b1 << F_ICX));
        probe("R4 text main overrides aux read", 16'h0400, 1'b0, 3'd0);
        probe("R4 hgr not in window", 16'h2000, 1'b0, 3'd3);
        apply((11'b1 << F_S80) | (11'b1 << F_P2) | (11'b1 << F_ICX));
        probe("R4 text aux read", 16'h0700, 1'b0, 3'd3);
        probe("R4 text aux write", 16'h0500, 1'b1, 3'd3);
        probe("R4 hgr off without hires", 16'h2000, 1'b0, 3'd0);
        apply((11'b1 << F_S80) | (11'b1 << F_P2) | (11'b1 << F_HR) | (11'b1 << F_ICX));
        probe("R4 hgr aux", 16'h3F00, 1'b1, 3'd3);
        probe("R4 above hgr", 16'h4000, 1'b0, 3'd0);
    endtask

    task automatic t_slots;
        apply(11'b1 << F_S3);
        probe("R6 C3 card", 16'hC300, 1'b0, 3'd7);
        probe("R6 C3 write rom", 16'hC300, 1'b1, 3'd6);
        apply((11'b1 << F_S3) | (11'b1 << F_ICX));
        probe("R6 C3 card under internal", 16'hC3FF, 1'b0, 3'd7);
        probe("R5 C7 internal", 16'hC700, 1'b0, 3'd6);
        probe("R5 C8 never card", 16'hC800, 1'b0, 3'd6);
    endtask

    task automatic t_upper;
        apply((11'b1 << F_URD) | (11'b1 << F_ICX));
        probe("R7 read upper", 16'hD000, 1'b0, 3'd1);
        probe("R7 write rom", 16'hD000, 1'b1, 3'd6);
        apply((11'b1 << F_URD) | (11'b1 << F_ZP) | (11'b1 << F_ICX));
        probe("R7 aux upper", 16'hE000, 1'b0, 3'd4);
        apply((11'b1 << F_URD) | (11'b1 << F_ZP) | (11'b1 << F_UB2) | (11'b1 << F_ICX));
        probe("R8 aux bank2", 16'hD000, 1'b0, 3'd5);
        probe("R8 above window", 16'hE000, 1'b0, 3'd4);
        apply((11'b1 << F_UWR) | (11'b1 << F_UB2) | (11'b1 << F_ICX));
        probe("R8 bank2 write", 16'hD800, 1'b1, 3'd2);
        probe("R8 bank2 read rom", 16'hD800, 1'b0, 3'd6);
        probe("R7 write upper", 16'hFFFF, 1'b1, 3'd1);
    endtask

    task automatic t_stale;
        apply(11'b1 << F_ICX);
        @(negedge clk);
        m = (11'b1 << F_ICX) | (11'b1 << F_ARD);
        #1;
        check("R10 stale same cycle", {3'b0, map_stale}, 4'd1);
        probe("R10 old map before edge", 16'h1000, 1'b0, 3'd0);
        @(negedge clk);
        check("R10 stale after one edge", {3'b0, map_stale}, 4'd1);
        probe("R10 old map after one edge", 16'h1000, 1'b0, 3'd0);
        @(negedge clk);
        check("R10 clear after two edges", {3'b0, map_stale}, 4'd0);
        probe("R10 new map in effect", 16'h1000, 1'b0, 3'd3);
    endtask

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        m        = '0;
        acc_addr = '0;
        acc_we   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_base();
        t_zero_page();
        t_split();
        t_display();
        t_slots();
        t_upper();
        t_stale();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule